// File: doc/BRIEF.md
# Periodic interrupt and square-wave generator

This block turns a fitted time base into the slow timing signals of a real-time clock. A prescaler reduces the time base to a common 32.768 kHz unit rate. A 15-bit counter running at that unit rate gives a one-second pulse and a family of binary taps. One tap, picked by a four-bit rate code, drives both a periodic interrupt flag and a square-wave pin. The time base may be 4.194304 MHz, 1.048576 MHz or 32.768 kHz. A three-bit base code tells the prescaler which of these is fitted, so the second stays exact for each one.

Three flags record a periodic event, an alarm match and the end of a calendar update. The alarm and update events arrive as one-cycle pulses from the calendar logic, which lies outside this block. Each flag has its own enable. Together they drive one active-low interrupt request. Reading the flag word clears all three flags. A clock output copies the time base, or divides it by four, as a select input chooses.

Top module: `tick_irq_gen`

## Requirements
- R1: The base code sets the number of clocks per unit (1/32768 s): 0 gives 128 clocks, 1 gives 32 clocks and 2 gives 1 clock. Any other code holds the divider chain cleared, so no periodic flag, square wave or one-second pulse appears.
- R2: `one_sec` is a one-clock pulse that repeats every 32768 units.
- R3: Rate codes 3 to 15 set the periodic flag once every 2^(rate-1) units. Rate code 0 never sets it.
- R4: Rate codes 1 and 2 give 2^(rate+6) units with base code 2, and 2^(rate-1) units with base codes 0 and 1.
- R5: `sqw` is a 50 % duty square wave whose period equals the periodic interval. It is held low when `sqw_en` is 0, when the rate code is 0, or when the chain is stopped.
- R6: Each event sets its flag whatever the state of its enable. `rd_data` bit 2 is the periodic flag, bit 1 the alarm flag, bit 0 the update flag, and bit 3 shows an active request.
- R7: `irq_n` is low exactly when some flag is set and its enable is 1.
- R8: A cycle with `flag_rd` high clears all three flags from the next cycle on, which releases `irq_n`.
- R9: An event that arrives in the same cycle as `flag_rd` leaves its flag set.
- R10: `ckout` follows `clk` when `ckout_full` is 1. Otherwise it is the clock divided by four, with a 50 % duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 3 | Fitted time-base code |
| rate | input | 4 | Periodic and square-wave rate code |
| sqw_en | input | 1 | Square-wave enable |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-ended interrupt enable |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| flag_rd | input | 1 | Flag word read strobe; clears the flags |
| ckout_full | input | 1 | Clock output select: 1 full rate, 0 quarter rate |
| rd_data | output | 4 | Flag word {request, periodic, alarm, update} |
| irq_n | output | 1 | Combined interrupt request, active low |
| sqw | output | 1 | Square-wave output |
| one_sec | output | 1 | One-second pulse |
| ckout | output | 1 | Clock output |

## Verification
Two actions can meet in the same clock cycle: a software read that clears the flags, and a new event that sets a flag. The bench drives `alarm_evt` in the same cycle as `flag_rd`. It then checks that the alarm flag and the request are still present afterwards. The periodic tests provoke this collision on every event, because they hold `flag_rd` high throughout. Each tap event must still appear as a one-cycle flag pulse, with the expected spacing between pulses.

// File: rtl/tick_irq_gen.sv
module tick_irq_gen #(
  parameter int SEC_W = 15,
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] base_sel,
  input  logic [3:0] rate,
  input  logic       sqw_en,
  input  logic       pie,
  input  logic       aie,
  input  logic       uie,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       flag_rd,
  input  logic       ckout_full,
  output logic [3:0] rd_data,
  output logic       irq_n,
  output logic       sqw,
  output logic       one_sec,
  output logic       ckout
);

  logic [PRE_W-1:0] pre, lim;
  logic [SEC_W-1:0] cnt, mask;
  logic [4:0]       k;
  logic [1:0]       ck4;
  logic run, pre_msb, en_unit, src, pevt, pf, af, uf, irq;

  always_comb begin
    run     = 1'b1;
    lim     = '0;
    pre_msb = 1'b0;
    case (base_sel)
      3'd0: begin
        lim     = {PRE_W{1'b1}};
        pre_msb = pre[PRE_W-1];
      end
      3'd1: begin
        lim     = {2'b00, {(PRE_W-2){1'b1}}};
        pre_msb = pre[PRE_W-3];
      end
      3'd2: ;
      default: run = 1'b0;
    endcase
  end

  always_comb begin
    if (rate == 4'd0)
      k = 5'd0;
    else if (rate >= 4'd3 || base_sel != 3'd2)
      k = 5'(rate) - 5'd1;
    else
      k = 5'(rate) + 5'd6;
    mask = (SEC_W'(1) << k) - SEC_W'(1);
    src  = (k == 5'd0) ? pre_msb : |(cnt & (SEC_W'(1) << 5'(k - 5'd1)));
  end

  assign en_unit = run && (pre == lim);
  assign pevt    = en_unit && (rate != 4'd0) && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre <= '0;
      cnt <= '0;
    end else if (en_unit) begin
      pre <= '0;
      cnt <= cnt + SEC_W'(1);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      one_sec <= 1'b0;
      pf      <= 1'b0;
      af      <= 1'b0;
      uf      <= 1'b0;
      ck4     <= 2'd0;
    end else begin
      one_sec <= en_unit && (&cnt);
      pf      <= pevt       | (pf & ~flag_rd);
      af      <= alarm_evt  | (af & ~flag_rd);
      uf      <= update_evt | (uf & ~flag_rd);
      ck4     <= ck4 + 2'd1;
    end
  end

  assign irq     = (pf & pie) | (af & aie) | (uf & uie);
  assign irq_n   = ~irq;
  assign rd_data = {irq, pf, af, uf};
  assign sqw     = sqw_en && run && (rate != 4'd0) && src;
  assign ckout   = ckout_full ? clk : ck4[1];

  assert_sec_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    one_sec |=> !one_sec);
  assert_no_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) && flag_rd |=> !rd_data[2]);
  assert_alarm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> rd_data[1]);
  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (rd_data[2:0] != 3'b000));
  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && !alarm_evt && !update_evt |=> (rd_data[1:0] == 2'b00));
  assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (base_sel > 3'd2) |-> !sqw);

endmodule

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] base_sel = 3'd2;
  logic [3:0] rate = 4'd0;
  logic sqw_en = 1'b0, pie = 1'b0, aie = 1'b0, uie = 1'b0;
  logic alarm_evt = 1'b0, update_evt = 1'b0, flag_rd = 1'b0, ckout_full = 1'b0;
  logic [3:0] rd_data;
  logic irq_n, sqw, one_sec, ckout;

  int total = 0, bad = 0, cyc = 0, last = 0;
  bit mon_on = 1'b0, have_last = 1'b0;
  int exp_q[$];
  string tag_q[$];

  tick_irq_gen u_dut (.clk, .rst_n, .base_sel, .rate, .sqw_en, .pie, .aie, .uie,
    .alarm_evt, .update_evt, .flag_rd, .ckout_full, .rd_data, .irq_n, .sqw,
    .one_sec, .ckout);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rd_data[2]) begin
      if (have_last && exp_q.size() > 0) check(tag_q.pop_front(), cyc - last, exp_q.pop_front());
      have_last = 1'b1;
      last = cyc;
    end
  end

  task automatic run_rate(logic [2:0] b, logic [3:0] r, int gap, string tag);
    mon_on = 1'b0;
    base_sel = b; rate = r; flag_rd = 1'b1;
    repeat (3) @(negedge clk);
    have_last = 1'b0;
    repeat (2) begin exp_q.push_back(gap); tag_q.push_back(tag); end
    mon_on = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int ones, gap;
    logic s [16];
    repeat (3) @(negedge clk);
    check("R6 reset flags", int'(rd_data), 0);
    check("R7 reset irq", int'(irq_n), 1);
    check("R2 reset pulse", int'(one_sec), 0);
    rst_n = 1'b1;

    run_rate(3'd2, 4'd3, 4, "R3 rate3 base2");
    run_rate(3'd2, 4'd1, 128, "R4 rate1 base2");
    run_rate(3'd2, 4'd2, 256, "R4 rate2 base2");
    run_rate(3'd1, 4'd1, 32, "R4 rate1 base1");
    run_rate(3'd0, 4'd2, 256, "R4 rate2 base0");
    run_rate(3'd0, 4'd6, 4096, "R1 rate6 base0");
    run_rate(3'd1, 4'd5, 512, "R1 rate5 base1");
    run_rate(3'd2, 4'd15, 16384, "R3 rate15 base2");

    // R2: one-second spacing at base 2
    while (!one_sec) @(negedge clk);
    gap = 0;
    @(negedge clk);
    check("R2 pulse width", int'(one_sec), 0);
    gap = 1;
    while (!one_sec) begin @(negedge clk); gap++; end
    check("R2 second period", gap, 32768);

    // R5: square wave
    base_sel = 3'd2; rate = 4'd4; sqw_en = 1'b1;
    repeat (2) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 16; i++) begin s[i] = sqw; ones += int'(sqw); @(negedge clk); end
    check("R5 duty", ones, 8);
    gap = 0;
    for (int i = 0; i < 12; i++) if (s[i] == s[i+4]) gap++;
    check("R5 half period", gap, 0);
    sqw_en = 1'b0; ones = 0;
    for (int i = 0; i < 16; i++) begin ones += int'(sqw); @(negedge clk); end
    check("R5 disabled low", ones, 0);
    sqw_en = 1'b1; rate = 4'd0; ones = 0;
    for (int i = 0; i < 16; i++) begin ones += int'(sqw); @(negedge clk); end
    check("R5 rate0 low", ones, 0);

    // R1: stopped chain
    base_sel = 3'd5; rate = 4'd3; flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
    ones = 0;
    for (int i = 0; i < 40; i++) begin ones += int'(rd_data[2]) + int'(one_sec) + int'(sqw); @(negedge clk); end
    check("R1 stopped chain", ones, 0);
    sqw_en = 1'b0;

    // R6/R7/R8: alarm, masked update
    rate = 4'd0; flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    aie = 1'b1; alarm_evt = 1'b1; @(negedge clk); alarm_evt = 1'b0;
    check("R6 alarm word", int'(rd_data), 4'b1010);
    check("R7 alarm irq", int'(irq_n), 0);
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    check("R8 cleared word", int'(rd_data), 0);
    check("R8 irq released", int'(irq_n), 1);
    update_evt = 1'b1; @(negedge clk); update_evt = 1'b0;
    check("R6 masked update word", int'(rd_data), 4'b0001);
    check("R7 masked irq", int'(irq_n), 1);
    uie = 1'b1; #1;
    check("R7 update enabled irq", int'(irq_n), 0);
    uie = 1'b0;

    // R9: event collides with read
    alarm_evt = 1'b1; flag_rd = 1'b1; @(negedge clk);
    alarm_evt = 1'b0; flag_rd = 1'b0;
    check("R9 alarm kept", int'(rd_data), 4'b1010);
    check("R9 irq kept", int'(irq_n), 0);
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0; aie = 1'b0;

    // R7: periodic enable
    base_sel = 3'd2; rate = 4'd3; pie = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 periodic irq", int'(irq_n), 0);
    pie = 1'b0; #1;
    check("R7 periodic masked", int'(irq_n), 1);
    check("R6 periodic flag", int'(rd_data[2]), 1);
    rate = 4'd0; flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;

    // R10: clock output
    ckout_full = 1'b0;
    for (int i = 0; i < 16; i++) begin s[i] = ckout; @(negedge clk); end
    ones = 0; gap = 0;
    for (int i = 0; i < 8; i++) ones += int'(s[i]);
    for (int i = 0; i < 14; i++) if (s[i] == s[i+2]) gap++;
    check("R10 quarter duty", ones, 4);
    check("R10 quarter period", gap, 0);
    ckout_full = 1'b1; #1;
    check("R10 full low", int'(ckout), 0);
    @(posedge clk); #1;
    check("R10 full high", int'(ckout), 1);

    finish_run();
  end
endmodule